// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment choice and a 16-bit offset into a 20-bit physical byte address within a 1 MiB space. It keeps four 16-bit segment registers. Each register gives the top 16 bits of a 20-bit segment base, so a register value `S` places its segment at byte `S * 16`. A request strobe picks one register through a 2-bit select and adds the zero-extended offset to that register's base. The sum appears on a registered output one clock later, with a valid flag.

A separate write port loads any one segment register. A read-back port shows the current contents of any register at once. Only the four loaded segments can be reached. To reach a different 64 KiB window, software rewrites a register. The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the block leaves reset two clock edges after the input rises.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the code register (select 01) reads 0xFFFF, the other three registers read 0x0000, and `addr_valid` is low.
- R2: The address for a request equals the selected register value times 16 plus the zero-extended offset.
- R3: A sum above 0xFFFFF keeps only its low 20 bits. Examples: code 0xFFFF with offset 0x0010 gives 0x00000, and 0xFFFF with offset 0xFFFF gives 0x0FFEF.
- R4: The select code picks the register as follows: 00 extra, 01 code, 10 stack, 11 data. This holds for requests, writes and read-back.
- R5: `addr_valid` is high in exactly the cycle after a cycle with `req_valid` high. In a cycle without a request `addr_out` keeps its previous value.
- R6: When a write and a request name the same register in the same cycle, the address uses the old register value. The new value applies from the next cycle.
- R7: A write changes only the selected register. `rd_data` shows the new value from the cycle after the write.
- R8: Pulling `rst_n` low clears `addr_valid` and restores the register reset values without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Register to write (00 extra, 01 code, 10 stack, 11 data) |
| seg_wr_data | input | 16 | Value to write |
| rd_sel | input | 2 | Register shown on `rd_data` |
| rd_data | output | 16 | Current contents of the selected register |
| req_valid | input | 1 | Address request strobe |
| req_sel | input | 2 | Segment used for the request |
| req_offset | input | 16 | Offset within the segment |
| addr_valid | output | 1 | Registered address is valid this cycle |
| addr_out | output | 20 | Registered physical address |

## Verification
The assertions expect every input to be held stable around the rising edge, and they treat the request and write strobes as plain single-cycle pulses with no handshake. They also expect no request while the internal reset is active. The bench therefore drives all inputs on the falling edge and drops each strobe after one cycle. It issues requests only after waiting out the two-edge reset release. It also places a write and a request on the same register in one cycle, so the old-value rule is exercised on purpose and never hit by accident.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W     = 16;
  localparam int OFF_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int ADDR_W    = 20;
  localparam int SEG_CNT   = 4;
  localparam int SEL_W     = $clog2(SEG_CNT);

  typedef enum logic [SEL_W-1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_sel_e;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int W   = SEG_W,
  parameter int CNT = SEG_CNT,
  localparam int SW = $clog2(CNT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [SW-1:0] a_sel,
  output logic [W-1:0]  a_data,
  input  logic [SW-1:0] b_sel,
  output logic [W-1:0]  b_data
);
  logic [W-1:0] seg_q [CNT];
  logic [W-1:0] seg_d [CNT];
  logic         seg_en [CNT];

  for (genvar i = 0; i < CNT; i++) begin : g_seg
    localparam logic [W-1:0] RST_VAL = (i == int'(SEG_CODE)) ? '1 : '0;

    always_comb begin
      seg_en[i] = wr_en && (wr_sel == SW'(i));
      seg_d[i]  = seg_en[i] ? wr_data : seg_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seg_q[i] <= RST_VAL;
      else        seg_q[i] <= seg_d[i];
    end

    // R7: unselected registers never change
    assert_wr_isolate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SW'(i)) |=> $stable(seg_q[i]));
    // R7: selected register takes the written value
    assert_wr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SW'(i)) |=> seg_q[i] == $past(wr_data));
  end

  always_comb begin
    a_data = seg_q[a_sel];
    b_data = seg_q[b_sel];
  end
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import seg_addr_pkg::*;
#(
  parameter int SW  = SEG_W,
  parameter int OW  = OFF_W,
  parameter int SH  = SEG_SHIFT,
  parameter int AW  = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [SW-1:0] seg_base,
  input  logic [OW-1:0] offset,
  output logic          addr_valid,
  output logic [AW-1:0] addr_out
);
  logic [AW-1:0] base_ext;
  logic [AW-1:0] off_ext;
  logic [AW-1:0] sum;
  logic [AW-1:0] addr_d;
  logic          valid_d;

  always_comb begin
    base_ext = AW'({seg_base, {SH{1'b0}}});
    off_ext  = AW'(offset);
    sum      = base_ext + off_ext;
    addr_d   = req_valid ? sum : addr_out;
    valid_d  = req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_out   <= '0;
    end else begin
      addr_valid <= valid_d;
      addr_out   <= addr_d;
    end
  end

  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> addr_valid);
  assert_valid_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !addr_valid);
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(addr_out));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_BITS  = SEG_W,
  parameter int OFF_BITS  = OFF_W,
  parameter int ADDR_BITS = ADDR_W,
  parameter int SHIFT     = SEG_SHIFT,
  localparam int SELB     = SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seg_wr_en,
  input  logic [SELB-1:0]      seg_wr_sel,
  input  logic [SEG_BITS-1:0]  seg_wr_data,
  input  logic [SELB-1:0]      rd_sel,
  output logic [SEG_BITS-1:0]  rd_data,
  input  logic                 req_valid,
  input  logic [SELB-1:0]      req_sel,
  input  logic [OFF_BITS-1:0]  req_offset,
  output logic                 addr_valid,
  output logic [ADDR_BITS-1:0] addr_out
);
  logic                rst_sync_n;
  logic [SEG_BITS-1:0] req_seg_val;
  logic                req_live;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  seg_regfile #(.W(SEG_BITS), .CNT(SEG_CNT)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(seg_wr_en), .wr_sel(seg_wr_sel), .wr_data(seg_wr_data),
    .a_sel(req_sel), .a_data(req_seg_val),
    .b_sel(rd_sel),  .b_data(rd_data)
  );

  always_comb req_live = req_valid && rst_sync_n;

  seg_addr_calc #(.SW(SEG_BITS), .OW(OFF_BITS), .SH(SHIFT), .AW(ADDR_BITS)) u_calc (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_live), .seg_base(req_seg_val), .offset(req_offset),
    .addr_valid(addr_valid), .addr_out(addr_out)
  );

  // R6: a collision uses the register value from before the write
  assert_old_value_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && seg_wr_en && seg_wr_sel == req_sel) |=>
      (addr_valid && addr_out == ADDR_BITS'({$past(req_seg_val), {SHIFT{1'b0}}})
                                  + ADDR_BITS'($past(req_offset))));
  // R8: while the external reset is low the output stays invalid
  assert_reset_clear_R8: assert property (@(posedge clk) !rst_n |-> !addr_valid);
endmodule

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = 2'd0;
  logic [15:0] seg_wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic        req_valid = 1'b0;
  logic [1:0]  req_sel = 2'd0;
  logic [15:0] req_offset = '0;
  logic        addr_valid;
  logic [19:0] addr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  seg_addr_gen uut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .req_valid(req_valid), .req_sel(req_sel), .req_offset(req_offset),
    .addr_valid(addr_valid), .addr_out(addr_out)
  );

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic readback(input logic [1:0] sel, output logic [15:0] v);
    @(negedge clk);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic seg_write(input logic [1:0] sel, input logic [15:0] v);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = v;
    @(negedge clk);
    seg_wr_en = 1'b0;
  endtask

  // one-cycle request; returns output sampled in the following cycle
  task automatic request(input logic [1:0] sel, input logic [15:0] off,
                         output logic v, output logic [19:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_sel = sel; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
    v = addr_valid; a = addr_out;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 valid low", 20'(addr_valid), 20'h0);
    readback(2'b00, v); check("R1 extra", 20'(v), 20'h0);
    readback(2'b01, v); check("R1 code", 20'(v), 20'hFFFF);
    readback(2'b10, v); check("R1 stack", 20'(v), 20'h0);
    readback(2'b11, v); check("R1 data", 20'(v), 20'h0);
  endtask

  task automatic t_wrap();
    logic vl; logic [19:0] a;
    request(2'b01, 16'h0010, vl, a); check("R3 wrap to zero", a, 20'h00000);
    seg_write(2'b11, 16'hFFFF);
    request(2'b11, 16'hFFFF, vl, a); check("R3 wrap max", a, 20'h0FFEF);
  endtask

  task automatic t_basic();
    logic vl; logic [19:0] a;
    seg_write(2'b00, 16'h1234);
    request(2'b00, 16'h0010, vl, a);
    check("R2 valid", 20'(vl), 20'h1);
    check("R2 sum", a, 20'h12350);
    request(2'b00, 16'hABCD, vl, a); check("R2 sum carry", a, 20'h1CF0D);
  endtask

  task automatic t_select();
    logic vl; logic [19:0] a; logic [15:0] v;
    seg_write(2'b00, 16'h1000);
    seg_write(2'b01, 16'h2000);
    seg_write(2'b10, 16'h3000);
    seg_write(2'b11, 16'h4000);
    request(2'b00, 16'h0001, vl, a); check("R4 extra", a, 20'h10001);
    request(2'b01, 16'h0002, vl, a); check("R4 code",  a, 20'h20002);
    request(2'b10, 16'h0003, vl, a); check("R4 stack", a, 20'h30003);
    request(2'b11, 16'h0004, vl, a); check("R4 data",  a, 20'h40004);
    readback(2'b10, v); check("R4 readback stack", 20'(v), 20'h3000);
  endtask

  task automatic t_latency();
    logic vl; logic [19:0] a;
    request(2'b10, 16'h0055, vl, a);
    check("R5 valid after req", 20'(vl), 20'h1);
    @(negedge clk);
    check("R5 valid drops", 20'(addr_valid), 20'h0);
    check("R5 addr holds", addr_out, 20'h30055);
  endtask

  task automatic t_collide();
    logic vl; logic [19:0] a;
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_sel = 2'b10; seg_wr_data = 16'h5000;
    req_valid = 1'b1; req_sel = 2'b10; req_offset = 16'h0005;
    @(negedge clk);
    seg_wr_en = 1'b0; req_valid = 1'b0;
    check("R6 old value used", addr_out, 20'h30005);
    request(2'b10, 16'h0005, vl, a); check("R6 new value next", a, 20'h50005);
  endtask

  task automatic t_isolate();
    logic [15:0] v;
    seg_write(2'b11, 16'hBEEF);
    readback(2'b11, v); check("R7 written", 20'(v), 20'hBEEF);
    readback(2'b00, v); check("R7 extra kept", 20'(v), 20'h1000);
    readback(2'b01, v); check("R7 code kept", 20'(v), 20'h2000);
    readback(2'b10, v); check("R7 stack kept", 20'(v), 20'h5000);
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    req_valid = 1'b1; req_sel = 2'b00; req_offset = 16'h0001;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 pre valid", 20'(addr_valid), 20'h1);
    #1 rst_n = 1'b0;
    #1 check("R8 valid cleared", 20'(addr_valid), 20'h0);
    rd_sel = 2'b01;
    #1 check("R8 code restored", 20'(rd_data), 20'hFFFF);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_wrap();
    t_basic();
    t_select();
    t_latency();
    t_collide();
    t_isolate();
    t_async_reset();
    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end
endmodule